// File: doc/BRIEF.md
# Supply Supervisor with Startup Pulse Inhibit

This block watches a digitised supply level and an external active-low clear pin, and from them produces the chip's internal active-low reset together with a pulse-enable. Downstream pulse generators must honour the pulse-enable. The reset holds whenever the clear pin is low or the supply is below its lower trip point. Once both are healthy again, reset is released. The pulse-enable then stays low for a long quiet window of `INHIBIT_CYCLES` master-clock cycles, which defaults to about one second at 3.58 MHz. A reset that arrives during that window starts the whole window again, so an unsettled supply that bounces cannot let pulses through early.

The supply level reaches the block in one of two forms, chosen by the parameter `USE_FLAGS`. The first form is a sampled supply code. The block compares it against a lower code `LO_CODE` (about 4.0 V) and an upper code `HI_CODE` (about 4.2 V), which gives a trip point with hysteresis. The second form is two comparator flags: one for "below the lower trip" and one for "above the upper trip". In both forms a level that sits between the two trip points leaves the supply verdict unchanged.

Sequencing is done by a three-state machine:
- `ST_HOLD`: reset asserted, pulses blocked.
- `ST_QUIET`: reset released, window counting.
- `ST_RUN`: pulses enabled.

Its transitions are:
- HOLD→QUIET when the synchronised clear and the supply verdict are both good.
- QUIET→HOLD and RUN→HOLD on any loss of either.
- QUIET→RUN when the counter reaches its last value.

Top module: `supply_guard`

## Requirements
- R1: Driving `clr_n_pin` low forces `rst_n_o` and `pulse_en_o` low at once, without waiting for a clock edge.
- R2: With the supply already good, `rst_n_o` rises on the third rising clock edge after `clr_n_pin` is released. The pin passes through a two-flop synchroniser first, and reset deasserts synchronously.
- R3: A supply code below `LO_CODE` clears the supply verdict on the next edge. `rst_n_o` falls on the edge after that.
- R4: A supply code at or above `HI_CODE` sets the supply verdict. A code in the band from `LO_CODE` up to `HI_CODE - 1` leaves both the verdict and the outputs in their current state.
- R5: While the block stays healthy, `pulse_en_o` rises exactly `INHIBIT_CYCLES` rising edges after `rst_n_o` rises.
- R6: Any loss of health during the quiet window returns the block to HOLD. After the next release, the full `INHIBIT_CYCLES` window is counted again.
- R7: `pulse_en_o` falls on the same edge on which `rst_n_o` falls, and it is never high while `rst_n_o` is low.
- R8: With `USE_FLAGS = 1`, a high `sup_below_lo` acts as a code below `LO_CODE`. A high `sup_above_hi` acts as a code at or above `HI_CODE`. With both low, the verdict holds. The outputs then match the code form cycle for cycle.
- R9: After a clear, the block sits in HOLD with `rst_n_o = 0` and `pulse_en_o = 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| clr_n_pin | input | 1 | External clear, active low, asynchronous |
| sup_code | input | CODE_W | Sampled supply code (used when USE_FLAGS = 0) |
| sup_below_lo | input | 1 | Comparator flag: supply under lower trip (used when USE_FLAGS = 1) |
| sup_above_hi | input | 1 | Comparator flag: supply over upper trip (used when USE_FLAGS = 1) |
| rst_n_o | output | 1 | Internal reset, active low |
| pulse_en_o | output | 1 | Pulse generators may emit only while high |

## Verification
The assertions assume that `sup_code` and the comparator flags change only between clock edges. They also assume the two flags are never high together, because the supply cannot be both below the lower trip and above the upper one. The bench drives every supply change at the falling clock edge. It feeds the flag-form instance with flags derived from the same code through the two thresholds, so the flags are mutually exclusive by construction. The clear pin is the only input allowed to change away from that edge, since it is asynchronous by definition.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,   // reset held, pulses blocked
        ST_QUIET = 2'd1,   // reset released, inhibit window running
        ST_RUN   = 2'd2    // pulses allowed
    } sg_state_e;

endpackage

// File: rtl/sg_clear_sync.sv
module sg_clear_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_n_pin,
    output logic clr_ok_o
);

    logic [STAGES-1:0] pipe_q;

    // Asynchronous assert, synchronous release
    always_ff @(posedge clk or negedge clr_n_pin) begin
        if (!clr_n_pin) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
        end
    end

    assign clr_ok_o = pipe_q[STAGES-1];

    // R2: the release never skips the first stage
    p_release_staged_r2: assert property (@(posedge clk) disable iff (!clr_n_pin)
        $rose(clr_ok_o) |-> $past(pipe_q[0]));

endmodule

// File: rtl/sg_level_detect.sv
module sg_level_detect #(
    parameter int          CODE_W    = 10,
    parameter logic [9:0]  LO_CODE   = 10'd400,
    parameter logic [9:0]  HI_CODE   = 10'd420,
    parameter bit          USE_FLAGS = 1'b0
) (
    input  logic              clk,
    input  logic              clr_n_pin,
    input  logic [CODE_W-1:0] sup_code,
    input  logic              sup_below_lo,
    input  logic              sup_above_hi,
    output logic              sup_ok_o
);

    localparam logic [CODE_W-1:0] LO_TH = CODE_W'(LO_CODE);
    localparam logic [CODE_W-1:0] HI_TH = CODE_W'(HI_CODE);

    logic ok_q;
    logic go_low;
    logic go_high;

    generate
        if (USE_FLAGS) begin : g_flags
            logic unused_code;
            assign unused_code = ^sup_code;
            assign go_low  = sup_below_lo;
            assign go_high = sup_above_hi;

            // R8: inputs assumed exclusive
            p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!clr_n_pin)
                !(sup_below_lo && sup_above_hi));
        end else begin : g_code
            logic unused_flags;
            assign unused_flags = sup_below_lo ^ sup_above_hi;
            assign go_low  = (sup_code < LO_TH);
            assign go_high = (sup_code >= HI_TH);

            // R4: a code inside the hysteresis band never moves the verdict
            p_band_holds_r4: assert property (@(posedge clk) disable iff (!clr_n_pin)
                (sup_code >= LO_TH && sup_code < HI_TH) |=> $stable(ok_q));
            // R3: a low code clears the verdict on the next edge
            p_low_clears_r3: assert property (@(posedge clk) disable iff (!clr_n_pin)
                (sup_code < LO_TH) |=> !ok_q);
        end
    endgenerate

    // Hysteresis register: low trip wins, high trip sets, band holds
    always_ff @(posedge clk or negedge clr_n_pin) begin
        if (!clr_n_pin) begin
            ok_q <= 1'b0;
        end else if (go_low) begin
            ok_q <= 1'b0;
        end else if (go_high) begin
            ok_q <= 1'b1;
        end
    end

    assign sup_ok_o = ok_q;

endmodule

// File: rtl/sg_inhibit_fsm.sv
module sg_inhibit_fsm
    import supply_guard_pkg::*;
#(
    parameter int INHIBIT_CYCLES = 3580000
) (
    input  logic clk,
    input  logic clr_n_pin,
    input  logic healthy_i,
    output logic rst_n_o,
    output logic pulse_en_o
);

    localparam int                CNT_W    = (INHIBIT_CYCLES > 2) ? $clog2(INHIBIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(INHIBIT_CYCLES - 1);

    sg_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             rst_q, en_q;

    // Next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HOLD: begin
                cnt_d = '0;
                if (healthy_i) begin
                    state_d = ST_QUIET;
                end
            end
            ST_QUIET: begin
                if (!healthy_i) begin
                    state_d = ST_HOLD;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ST_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_RUN: begin
                if (!healthy_i) begin
                    state_d = ST_HOLD;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge clr_n_pin) begin
        if (!clr_n_pin) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered outputs decoded from the next state
    always_ff @(posedge clk or negedge clr_n_pin) begin
        if (!clr_n_pin) begin
            rst_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            rst_q <= (state_d != ST_HOLD);
            en_q  <= (state_d == ST_RUN);
        end
    end

    assign rst_n_o    = rst_q;
    assign pulse_en_o = en_q;

    // R5: the window counter advances by one each healthy quiet cycle
    p_count_step_r5: assert property (@(posedge clk) disable iff (!clr_n_pin)
        (state_q == ST_QUIET && healthy_i && cnt_q != CNT_LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R6: loss of health in the window goes back to HOLD
    p_restart_r6: assert property (@(posedge clk) disable iff (!clr_n_pin)
        (state_q == ST_QUIET && !healthy_i) |=> (state_q == ST_HOLD && cnt_q == '0));
    // R7: leaving RUN drops both outputs together
    p_drop_together_r7: assert property (@(posedge clk) disable iff (!clr_n_pin)
        (state_q == ST_RUN && !healthy_i) |=> (!rst_q && !en_q));

endmodule

// File: rtl/supply_guard.sv
module supply_guard #(
    parameter int         CODE_W         = 10,
    parameter logic [9:0] LO_CODE        = 10'd400,
    parameter logic [9:0] HI_CODE        = 10'd420,
    parameter bit         USE_FLAGS      = 1'b0,
    parameter int         INHIBIT_CYCLES = 3580000
) (
    input  logic              clk,
    input  logic              clr_n_pin,
    input  logic [CODE_W-1:0] sup_code,
    input  logic              sup_below_lo,
    input  logic              sup_above_hi,
    output logic              rst_n_o,
    output logic              pulse_en_o
);

    logic clr_ok;
    logic sup_ok;
    logic healthy;

    sg_clear_sync #(
        .STAGES(2)
    ) u_sync (
        .clk       (clk),
        .clr_n_pin (clr_n_pin),
        .clr_ok_o  (clr_ok)
    );

    sg_level_detect #(
        .CODE_W    (CODE_W),
        .LO_CODE   (LO_CODE),
        .HI_CODE   (HI_CODE),
        .USE_FLAGS (USE_FLAGS)
    ) u_level (
        .clk          (clk),
        .clr_n_pin    (clr_n_pin),
        .sup_code     (sup_code),
        .sup_below_lo (sup_below_lo),
        .sup_above_hi (sup_above_hi),
        .sup_ok_o     (sup_ok)
    );

    assign healthy = clr_ok & sup_ok;

    sg_inhibit_fsm #(
        .INHIBIT_CYCLES(INHIBIT_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .clr_n_pin  (clr_n_pin),
        .healthy_i  (healthy),
        .rst_n_o    (rst_n_o),
        .pulse_en_o (pulse_en_o)
    );

    // R7: pulses never enabled while reset is asserted
    p_en_needs_rst_r7: assert property (@(posedge clk) disable iff (!clr_n_pin)
        pulse_en_o |-> rst_n_o);
    // R3: a lost supply verdict forces reset on the next edge
    p_sup_loss_r3: assert property (@(posedge clk) disable iff (!clr_n_pin)
        !sup_ok |=> !rst_n_o);

endmodule

// File: tb/test_supply_guard.sv
module test_supply_guard;

    localparam int CLK_P = 10;
    localparam int INH   = 20;
    localparam int LO    = 400;
    localparam int HI    = 420;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic [9:0] code = '0;
    logic       f_lo, f_hi;
    logic       rst_a, en_a, rst_b, en_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign f_lo = (code < LO);
    assign f_hi = (code >= HI);

    supply_guard #(.USE_FLAGS(1'b0), .INHIBIT_CYCLES(INH)) i_supply_guard (
        .clk(clk), .clr_n_pin(clr_n), .sup_code(code),
        .sup_below_lo(1'b0), .sup_above_hi(1'b0),
        .rst_n_o(rst_a), .pulse_en_o(en_a));

    supply_guard #(.USE_FLAGS(1'b1), .INHIBIT_CYCLES(INH)) i_supply_guard_flg (
        .clk(clk), .clr_n_pin(clr_n), .sup_code(10'd0),
        .sup_below_lo(f_lo), .sup_above_hi(f_hi),
        .rst_n_o(rst_b), .pulse_en_o(en_b));

    // Behavioural reference: two sync flops, hysteresis flag, phase count
    bit m_s1, m_s2, m_ok;
    int m_q;   // -1 hold, 0..INH-1 quiet, INH run
    always @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            m_s1 <= 0; m_s2 <= 0; m_ok <= 0; m_q <= -1;
        end else begin
            m_s1 <= 1; m_s2 <= m_s1;
            if (code < LO) m_ok <= 0;
            else if (code >= HI) m_ok <= 1;
            if (!(m_s2 && m_ok)) m_q <= -1;
            else if (m_q == -1) m_q <= 0;
            else if (m_q < INH - 1) m_q <= m_q + 1;
            else m_q <= INH;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison
    always @(negedge clk) begin
        if (!done) begin
            chk(rst_a == (m_q >= 0), "R5 code rst", rst_a, m_q >= 0);
            chk(en_a == (m_q == INH), "R5 code en", en_a, m_q == INH);
            chk(rst_b == (m_q >= 0), "R8 flag rst", rst_b, m_q >= 0);
            chk(en_b == (m_q == INH), "R8 flag en", en_b, m_q == INH);
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int n;
        cycles(4);
        chk(rst_a == 0 && en_a == 0, "R9 reset state", {rst_a, en_a}, 0);
        code = 10'd450;
        cycles(2);
        clr_n = 1'b1;
        n = 0;
        while (!rst_a && n < 10) begin @(negedge clk); n++; end
        chk(n == 3, "R2 sync release edges", n, 3);
        n = 0;
        while (!en_a && n < INH + 10) begin @(negedge clk); n++; end
        chk(n == INH, "R5 inhibit length", n, INH);
        // hover in RUN
        code = 10'd405;
        cycles(15);
        chk(en_a == 1 && rst_a == 1, "R4 band holds run", {rst_a, en_a}, 3);
        code = 10'd450;
        cycles(2);
        // supply drop
        code = 10'd390;
        @(negedge clk);
        chk(rst_a == 1, "R3 one edge later", rst_a, 1);
        @(negedge clk);
        chk(rst_a == 0, "R3 reset after two edges", rst_a, 0);
        chk(en_a == 0, "R7 en falls with rst", en_a, 0);
        // hover in HOLD
        code = 10'd415;
        cycles(15);
        chk(rst_a == 0, "R4 band holds reset", rst_a, 0);
        code = 10'd430;
        n = 0;
        while (!rst_a && n < 10) begin @(negedge clk); n++; end
        chk(n == 2, "R4 high code release", n, 2);
        // glitch inside the window
        cycles(INH / 2);
        code = 10'd380;
        @(negedge clk);
        code = 10'd440;
        @(negedge clk);
        chk(rst_a == 0 && en_a == 0, "R6 glitch back to hold", {rst_a, en_a}, 0);
        n = 0;
        while (!rst_a && n < 10) begin @(negedge clk); n++; end
        n = 0;
        while (!en_a && n < INH + 10) begin @(negedge clk); n++; end
        chk(n == INH, "R6 full window recounted", n, INH);
        // asynchronous clear
        cycles(3);
        #(CLK_P/5);
        clr_n = 1'b0;
        #1;
        chk(rst_a == 0 && en_a == 0, "R1 async clear code", {rst_a, en_a}, 0);
        chk(rst_b == 0 && en_b == 0, "R1 async clear flag", {rst_b, en_b}, 0);
        cycles(3);
        chk(rst_a == 0 && en_a == 0, "R9 held in clear", {rst_a, en_a}, 0);
        clr_n = 1'b1;
        cycles(INH + 8);
        chk(en_a == 1 && en_b == 1, "R5 run after clear", {en_a, en_b}, 3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R5 act=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule